// File: doc/BRIEF.md
# Character Clock Recovery for Asynchronous Serial Data

This block sits behind an FSK receiver that delivers a demodulated bit stream at roughly 1200 baud, together with a carrier qualifier. It watches the stream for a high-to-low change that marks the start of a 10-bit character: one low start bit, eight data bits sent least significant bit first, and one high stop bit. For each character it drives a burst of eight active-low clock pulses on `bclk_n`. Each pulse ends with its rising edge at the centre of one data bit. A downstream shift register therefore captures the eight data bits on those edges.

Once the eighth pulse has ended, the block pulls the active-low ready strobe `rdy_n` low. A consumer uses that strobe to take the assembled byte. The block also re-times the serial data onto `ser_out`, and holds that output at logic 1 whenever the carrier qualifier is inactive. The bit period is `DIV` master-clock cycles. The default of 2976 gives about 1202.8 bit/s from a 3.579545 MHz clock. A start event is accepted only if the line is still low half a bit period after the falling edge.

Top module: `char_clock_recovery`

## Requirements
- R1: While `carrier_ok` is 1, `ser_out` repeats `line_in` delayed by `SYNC_STAGES`+1 clock cycles. While `carrier_ok` is 0, `ser_out` is 1 from the next cycle on. After reset `ser_out` is 1.
- R2: Each accepted character produces exactly `DATA_BITS` (8) low pulses on `bclk_n`. The value of `ser_out` at the k-th rising edge is data bit k, counting from the least significant bit.
- R3: Every pulse on `bclk_n` is low for `DIV/2` cycles. The first rising edge follows the `line_in` falling edge by `SYNC_STAGES`+1+`DIV`+`DIV/2` cycles, with the input driven just after a negative clock edge. Later rising edges are `DIV` cycles apart.
- R4: `bclk_n` stays high during the start bit, during the stop bit, and while the line is idle.
- R5: `rdy_n` goes low on the same cycle as the rising edge of the last pulse. It stays low until the start bit of the next character is confirmed, then returns high before that character's first pulse. After reset `rdy_n` is 1.
- R6: A burst begins only on a change from high to low. A line that is already low when reset ends or when carrier appears produces no pulses until it has gone high and then low again.
- R7: A low excursion that has ended before half a bit period produces no pulses and leaves `rdy_n` unchanged.
- R8: When `carrier_ok` drops, `bclk_n` and `rdy_n` are both 1 from the next cycle, and any burst in progress is abandoned. Once carrier returns, the next character is recovered normally.
- R9: Elaboration stops when `DIV` is below 4, when `SYNC_STAGES` is outside 1 to 3, or when `DATA_BITS` is below 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Demodulated serial bit (mark = 1, space = 0) |
| carrier_ok | input | 1 | Carrier present qualifier, active high |
| ser_out | output | 1 | Re-timed serial data, forced high without carrier |
| bclk_n | output | 1 | Active-low data clock burst, rising edge mid-bit |
| rdy_n | output | 1 | Active-low character ready strobe |

## Verification
The properties assume that `carrier_ok` is synchronous to `clk`. The pulse-length property also assumes that carrier stays up for the whole of any pulse it judges. Only a carrier drop can shorten a pulse, so that property excuses the pulse edge that follows a drop. The stimulus changes the inputs one time unit after a falling clock edge and sends characters at exactly `DIV` cycles per bit. It drops carrier only in the deliberate abort scenario, so every complete burst meets those assumptions.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

   typedef enum logic [2:0] {
      PH_IDLE    = 3'd0,
      PH_CONFIRM = 3'd1,
      PH_GAP     = 3'd2,
      PH_LOW     = 3'd3,
      PH_HIGH    = 3'd4,
      PH_STOP    = 3'd5
   } phase_e;

endpackage

// File: rtl/ccr_line_sync.sv
// Synchronises the serial line and flags a high-to-low change on the
// synchronised copy. The chain resets low so a line that is low at reset
// never looks like a fresh start event.
module ccr_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic line_q,
   output logic fall
);

   logic prev_q;

   generate
      if (STAGES == 1) begin : g_one
         logic s0;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s0 <= 1'b0;
            else        s0 <= line_in;
         end
         assign line_q = s0;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], line_in};
         end
         assign line_q = chain[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= line_q;
   end

   assign fall = prev_q & ~line_q;

endmodule

// File: rtl/ccr_phase_timer.sv
// Down-counter: a load of N keeps the sequencer in its phase for N cycles.
module ccr_phase_timer #(
   parameter int WIDTH = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   output logic             expired
);

   logic [WIDTH-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= load_val - WIDTH'(1);
      else if (cnt != '0)   cnt <= cnt - WIDTH'(1);
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/ccr_burst_fsm.sv
// Phase sequencer: confirm the start bit at its centre, then alternate
// low and high clock phases once per data bit, then wait for the stop bit.
module ccr_burst_fsm
   import ccr_pkg::*;
#(
   parameter int DIV       = 2976,
   parameter int DATA_BITS = 8,
   parameter int CW        = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          line_q,
   input  logic          fall,
   input  logic          carrier_ok,
   input  logic          expired,
   output logic          load,
   output logic [CW-1:0] load_val,
   output logic          bclk_n,
   output logic          rdy_n
);

   localparam int HALF = DIV / 2;
   localparam int BW   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
   localparam logic [CW-1:0] HALF_V = CW'(HALF);
   localparam logic [CW-1:0] REST_V = CW'(DIV - HALF);
   localparam logic [BW-1:0] LAST_V = BW'(DATA_BITS - 1);

   phase_e          ph_q, ph_d;
   logic [BW-1:0]   bit_q;
   logic            confirm_ok;
   logic            last_low_end;
   logic            next_bit;

   assign confirm_ok   = carrier_ok && (ph_q == PH_CONFIRM) && expired && !line_q;
   assign last_low_end = carrier_ok && (ph_q == PH_LOW) && expired && (bit_q == LAST_V);
   assign next_bit     = carrier_ok && (ph_q == PH_HIGH) && expired;

   always_comb begin
      ph_d     = ph_q;
      load     = 1'b0;
      load_val = '0;
      if (!carrier_ok) begin
         ph_d = PH_IDLE;
      end else begin
         unique case (ph_q)
            PH_IDLE: if (fall) begin
               ph_d = PH_CONFIRM; load = 1'b1; load_val = HALF_V;
            end
            PH_CONFIRM: if (expired) begin
               if (!line_q) begin
                  ph_d = PH_GAP; load = 1'b1; load_val = REST_V;
               end else begin
                  ph_d = PH_IDLE;
               end
            end
            PH_GAP: if (expired) begin
               ph_d = PH_LOW; load = 1'b1; load_val = HALF_V;
            end
            PH_LOW: if (expired) begin
               if (bit_q == LAST_V) begin
                  ph_d = PH_STOP;
               end else begin
                  ph_d = PH_HIGH; load = 1'b1; load_val = REST_V;
               end
            end
            PH_HIGH: if (expired) begin
               ph_d = PH_LOW; load = 1'b1; load_val = HALF_V;
            end
            PH_STOP: if (line_q) ph_d = PH_IDLE;
            default: ph_d = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         bit_q <= '0;
      end else begin
         ph_q <= ph_d;
         if (confirm_ok)    bit_q <= '0;
         else if (next_bit) bit_q <= bit_q + BW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            rdy_n <= 1'b1;
      else if (!carrier_ok)  rdy_n <= 1'b1;
      else if (confirm_ok)   rdy_n <= 1'b1;
      else if (last_low_end) rdy_n <= 1'b0;
   end

   assign bclk_n = (ph_q != PH_LOW);

endmodule

// File: rtl/char_clock_recovery.sv
module char_clock_recovery #(
   parameter int DIV         = 2976,
   parameter int DATA_BITS   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   input  logic carrier_ok,
   output logic ser_out,
   output logic bclk_n,
   output logic rdy_n
);

   localparam int CW = $clog2(DIV + 1);

   // R9: parameter legality
   generate
      if (DIV < 4) begin : g_bad_div
         $error("char_clock_recovery: DIV must be at least 4");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("char_clock_recovery: SYNC_STAGES must be 1 to 3");
      end
      if (DATA_BITS < 2) begin : g_bad_bits
         $error("char_clock_recovery: DATA_BITS must be at least 2");
      end
   endgenerate

   logic          line_q;
   logic          fall;
   logic          load;
   logic [CW-1:0] load_val;
   logic          expired;

   ccr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (line_in),
      .line_q  (line_q),
      .fall    (fall)
   );

   ccr_phase_timer #(.WIDTH(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .expired  (expired)
   );

   ccr_burst_fsm #(.DIV(DIV), .DATA_BITS(DATA_BITS), .CW(CW)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_q     (line_q),
      .fall       (fall),
      .carrier_ok (carrier_ok),
      .expired    (expired),
      .load       (load),
      .load_val   (load_val),
      .bclk_n     (bclk_n),
      .rdy_n      (rdy_n)
   );

   // R1: gated, re-timed data output
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ser_out <= 1'b1;
      else        ser_out <= carrier_ok ? line_q : 1'b1;
   end

endmodule

// File: rtl/ccr_checker.sv
module ccr_checker #(
   parameter int HALF      = 1488,
   parameter int DATA_BITS = 8
) (
   input logic clk,
   input logic rst_n,
   input logic carrier_ok,
   input logic ser_out,
   input logic bclk_n,
   input logic rdy_n
);

   logic        bclk_d, rdy_d;
   logic [7:0]  fall_cnt;
   logic [31:0] low_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_d   <= 1'b1;
         rdy_d    <= 1'b1;
         fall_cnt <= '0;
         low_len  <= '0;
      end else begin
         bclk_d  <= bclk_n;
         rdy_d   <= rdy_n;
         low_len <= bclk_n ? 32'd0 : low_len + 32'd1;
         if (!carrier_ok || (rdy_n && !rdy_d)) fall_cnt <= '0;
         else if (!bclk_n && bclk_d)           fall_cnt <= fall_cnt + 8'd1;
      end
   end

   assert_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !carrier_ok |=> ser_out);

   assert_burst_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bclk_n) |-> (32'(fall_cnt) < DATA_BITS));

   assert_pulse_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bclk_n) && $past(carrier_ok)) |-> (low_len == 32'(HALF)));

   assert_ready_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rdy_n) |-> ($rose(bclk_n) && (32'(fall_cnt) == DATA_BITS)));

   assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !carrier_ok |=> (bclk_n && rdy_n));

endmodule

bind char_clock_recovery ccr_checker #(.HALF(DIV / 2), .DATA_BITS(DATA_BITS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .carrier_ok (carrier_ok),
   .ser_out    (ser_out),
   .bclk_n     (bclk_n),
   .rdy_n      (rdy_n)
);

// File: tb/tb_char_clock_recovery.sv
module tb_char_clock_recovery;

   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 16;
   localparam int HALF       = DIV / 2;
   localparam int STG        = 2;
   localparam int NB         = 8;
   localparam int FIRST_DLY  = 1 + STG + DIV + HALF;
   localparam int NVEC       = 6;
   localparam logic [7:0] VEC [0:NVEC-1] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line_in = 1'b1;
   logic carrier_ok = 1'b1;
   logic ser_out, bclk_n, rdy_n;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   int         pulses;
   logic [7:0] cap;
   int         t_first, t_last, t_rdy;
   logic       rdy_at_first;
   logic       bclk_p = 1'b1;
   logic       rdy_p = 1'b1;

   char_clock_recovery #(.DIV(DIV), .DATA_BITS(NB), .SYNC_STAGES(STG)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_in    (line_in),
      .carrier_ok (carrier_ok),
      .ser_out    (ser_out),
      .bclk_n     (bclk_n),
      .rdy_n      (rdy_n)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   // Monitor on the falling edge, away from the active edge.
   always @(negedge clk) begin
      if (bclk_n && !bclk_p) begin
         if (pulses == 0) begin
            t_first      = cyc;
            rdy_at_first = rdy_n;
         end
         t_last = cyc;
         cap    = {ser_out, cap[7:1]};
         pulses = pulses + 1;
      end
      if (!rdy_n && rdy_p) t_rdy = cyc;
      bclk_p = bclk_n;
      rdy_p  = rdy_n;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic clear_mon();
      pulses = 0; cap = '0; t_first = -1; t_last = -1; t_rdy = -1; rdy_at_first = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, output int t0);
      t0 = cyc;
      line_in = 1'b0;
      tick(DIV);
      for (int i = 0; i < 8; i++) begin
         line_in = b[i];
         tick(DIV);
      end
      line_in = 1'b1;
      tick(DIV);
      tick(2 * DIV);
   endtask

   task automatic check_char(input logic [7:0] b, input string ctx);
      int t0;
      clear_mon();
      send_byte(b, t0);
      chk(pulses == NB, {"R2 R4 pulse count ", ctx}, pulses, NB);
      chk(cap == b, {"R2 captured byte ", ctx}, int'(cap), int'(b));
      chk(t_first - t0 == FIRST_DLY, {"R3 first edge delay ", ctx}, t_first - t0, FIRST_DLY);
      chk(t_last - t_first == (NB - 1) * DIV, {"R3 edge spacing ", ctx}, t_last - t_first, (NB - 1) * DIV);
      chk(t_rdy == t_last, {"R5 ready with last edge ", ctx}, t_rdy, t_last);
      chk(rdy_at_first == 1'b1, {"R5 ready released before first edge ", ctx}, int'(rdy_at_first), 1);
      chk(rdy_n == 1'b0, {"R5 ready held low ", ctx}, int'(rdy_n), 0);
   endtask

   // Watchdog
   initial begin
      wait (cyc > 150000);
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      clear_mon();
      tick(5);
      rst_n = 1'b1;
      tick(4 * DIV);

      // Reset state
      chk(bclk_n == 1'b1, "R4 reset bclk_n", int'(bclk_n), 1);
      chk(rdy_n == 1'b1, "R5 reset rdy_n", int'(rdy_n), 1);
      chk(ser_out == 1'b1, "R1 reset/idle ser_out", int'(ser_out), 1);

      // Vector table walk
      for (int v = 0; v < NVEC; v++) check_char(VEC[v], $sformatf("vec%0d", v));

      // R7: short low glitch, ready must stay low
      clear_mon();
      line_in = 1'b0;
      tick(HALF - 3);
      line_in = 1'b1;
      tick(3 * DIV);
      chk(pulses == 0, "R7 glitch pulses", pulses, 0);
      chk(rdy_n == 1'b0, "R7 glitch leaves rdy_n", int'(rdy_n), 0);

      // R8: carrier loss releases ready
      carrier_ok = 1'b0;
      tick(2);
      chk(rdy_n == 1'b1, "R8 carrier loss rdy_n", int'(rdy_n), 1);
      chk(ser_out == 1'b1, "R1 gated ser_out", int'(ser_out), 1);

      // R1 / R6: line low while carrier absent, then carrier returns
      clear_mon();
      line_in = 1'b0;
      tick(DIV);
      chk(ser_out == 1'b1, "R1 ser_out held high without carrier", int'(ser_out), 1);
      carrier_ok = 1'b1;
      tick(3 * DIV);
      chk(pulses == 0, "R6 no burst from already-low line", pulses, 0);
      chk(ser_out == 1'b0, "R1 ser_out follows line", int'(ser_out), 0);
      line_in = 1'b1;
      tick(DIV);
      chk(ser_out == 1'b1, "R1 ser_out follows line high", int'(ser_out), 1);
      check_char(8'hC3, "after R6");

      // R8: abort mid-burst
      clear_mon();
      line_in = 1'b0;
      tick(DIV);
      for (int i = 0; i < 3; i++) begin
         line_in = 1'b1;
         tick(DIV);
      end
      carrier_ok = 1'b0;
      tick(2);
      chk(bclk_n == 1'b1, "R8 abort bclk_n", int'(bclk_n), 1);
      chk(rdy_n == 1'b1, "R8 abort rdy_n", int'(rdy_n), 1);
      tick(8 * DIV);
      chk(pulses == 3, "R8 burst abandoned", pulses, 3);
      line_in = 1'b1;
      carrier_ok = 1'b1;
      tick(DIV);
      check_char(8'h3C, "after R8 abort");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule